// File: doc/BRIEF.md
# Decode Operand Bypass and Load-Use Interlock

This block is the combinational hazard logic that sits beside the decode stage of a five-stage in-order core. In this core the only instruction that writes a register is a load. The block picks the two decode operand values. Each operand comes from the load that is finishing in the memory stage, from the value waiting in the memory/writeback bank, or from the register file. Bypass happens only into the end of decode, and the memory stage has fixed priority over writeback.

The block also finds the load-use case. A load sits in execute and its destination matches either decode source. The block does not check whether that operand is really consumed. When the case occurs, the fetch and decode banks hold for one cycle and the decode/execute bank takes a no-op bubble. That bubble gives the load one more cycle, so its data can reach decode through the memory-stage path. Loaded data is never forwarded into execute, not even for a store that follows a load directly.

The register ID 4'hF means "no register". Stages that hold a bubble carry this ID as their destination, so a bubble never matches a source.

Top module: `fwd_hazard_ctrl`

## Requirements
- R1: A decode source ID equal to 4'hF gives an operand value of 0, whatever the register-file data and the destination IDs are.
- R2: When a source ID is not 4'hF and equals the memory-stage destination, the operand is the memory-stage load value, even if the writeback destination also matches.
- R3: When a source ID is not 4'hF, equals the writeback destination and does not equal the memory-stage destination, the operand is the writeback value.
- R4: When a source ID is not 4'hF and matches neither the memory-stage nor the writeback destination, the operand is the register-file read data for that port.
- R5: Operand B follows the same selection rules as operand A, using its own source ID and register-file data, and is independent of operand A's inputs.
- R6: When the execute-stage destination is not 4'hF and equals either decode source ID, stall_fetch, stall_decode and bubble_execute are all 1.
- R7: When the execute-stage destination is 4'hF, or matches neither source ID, all three control outputs are 0. A source ID of 4'hF never causes a stall.
- R8: A destination ID of 4'hF in the memory or writeback stage never supplies an operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_src_a | input | 4 | Decode source ID for operand A |
| dec_src_b | input | 4 | Decode source ID for operand B |
| rf_data_a | input | 64 | Register-file read data, port A |
| rf_data_b | input | 64 | Register-file read data, port B |
| ex_dst | input | 4 | Destination ID of the load in execute (4'hF if none) |
| mem_dst | input | 4 | Destination ID of the load in memory |
| mem_load_val | input | 64 | Value the memory-stage load is about to write into the writeback bank |
| wb_dst | input | 4 | Destination ID held in the memory/writeback bank |
| wb_val | input | 64 | Value held in the memory/writeback bank |
| opnd_a | output | 64 | Operand A at the end of decode |
| opnd_b | output | 64 | Operand B at the end of decode |
| stall_fetch | output | 1 | Hold the fetch bank |
| stall_decode | output | 1 | Hold the decode bank |
| bubble_execute | output | 1 | Load a no-op into the decode/execute bank |

## Verification
The hardest case to reach is a single source ID that matches both the memory-stage and the writeback destination while the register file holds a different value. Only then does the fixed priority between the two bypass paths show. The stimulus sweeps every source ID against every pair of memory and writeback destinations, so the double match and the 4'hF combinations all occur. A second sweep covers every triple of the two source IDs and the execute destination, to cover the interlock. Every data input carries a value encoded from its own ID, so a wrong path gives a value that cannot be mistaken for the right one.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
    localparam int REG_ID_W = 4;
    localparam int DATA_W   = 64;
    localparam int NUM_SRC  = 2;

    typedef logic [REG_ID_W-1:0] reg_id_t;
    typedef logic [DATA_W-1:0]   word_t;

    localparam reg_id_t REG_NONE = '1;

    typedef struct packed {
        logic stall_fetch;
        logic stall_decode;
        logic bubble_execute;
    } pipe_ctrl_t;

    function automatic logic id_live(reg_id_t id);
        return id != REG_NONE;
    endfunction

    function automatic logic ids_hit(reg_id_t src, reg_id_t dst);
        return id_live(src) && id_live(dst) && (src == dst);
    endfunction
endpackage

// File: rtl/fwd_operand_sel.sv
module fwd_operand_sel
    import fwd_pkg::*;
(
    input  reg_id_t src,
    input  word_t   rf_val,
    input  reg_id_t mem_dst,
    input  word_t   mem_val,
    input  reg_id_t wb_dst,
    input  word_t   wb_val,
    output word_t   operand
);
    always_comb begin
        if (!id_live(src))               operand = '0;
        else if (ids_hit(src, mem_dst))  operand = mem_val;
        else if (ids_hit(src, wb_dst))   operand = wb_val;
        else                             operand = rf_val;
    end
endmodule

// File: rtl/load_use_detect.sv
module load_use_detect
    import fwd_pkg::*;
(
    input  reg_id_t srcs [NUM_SRC],
    input  reg_id_t ex_dst,
    output logic    hazard
);
    logic [NUM_SRC-1:0] hit;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_hit
        assign hit[i] = ids_hit(srcs[i], ex_dst);
    end

    assign hazard = |hit;
endmodule

// File: rtl/pipe_ctrl_gen.sv
module pipe_ctrl_gen
    import fwd_pkg::*;
(
    input  logic       hazard,
    output pipe_ctrl_t ctrl
);
    always_comb begin
        ctrl                = '0;
        ctrl.stall_fetch    = hazard;
        ctrl.stall_decode   = hazard;
        ctrl.bubble_execute = hazard;
    end
endmodule

// File: rtl/fwd_hazard_ctrl.sv
module fwd_hazard_ctrl
    import fwd_pkg::*;
(
    input  logic [REG_ID_W-1:0] dec_src_a,
    input  logic [REG_ID_W-1:0] dec_src_b,
    input  logic [DATA_W-1:0]   rf_data_a,
    input  logic [DATA_W-1:0]   rf_data_b,
    input  logic [REG_ID_W-1:0] ex_dst,
    input  logic [REG_ID_W-1:0] mem_dst,
    input  logic [DATA_W-1:0]   mem_load_val,
    input  logic [REG_ID_W-1:0] wb_dst,
    input  logic [DATA_W-1:0]   wb_val,
    output logic [DATA_W-1:0]   opnd_a,
    output logic [DATA_W-1:0]   opnd_b,
    output logic                stall_fetch,
    output logic                stall_decode,
    output logic                bubble_execute
);
    reg_id_t    srcs [NUM_SRC];
    word_t      rf   [NUM_SRC];
    word_t      opnd [NUM_SRC];
    logic       hazard;
    pipe_ctrl_t ctrl;

    assign srcs[0] = dec_src_a;
    assign srcs[1] = dec_src_b;
    assign rf[0]   = rf_data_a;
    assign rf[1]   = rf_data_b;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_opnd
        fwd_operand_sel u_sel (
            .src     (srcs[i]),
            .rf_val  (rf[i]),
            .mem_dst (mem_dst),
            .mem_val (mem_load_val),
            .wb_dst  (wb_dst),
            .wb_val  (wb_val),
            .operand (opnd[i])
        );
    end

    load_use_detect u_lud (
        .srcs   (srcs),
        .ex_dst (ex_dst),
        .hazard (hazard)
    );

    pipe_ctrl_gen u_ctrl (
        .hazard (hazard),
        .ctrl   (ctrl)
    );

    assign opnd_a         = opnd[0];
    assign opnd_b         = opnd[1];
    assign stall_fetch    = ctrl.stall_fetch;
    assign stall_decode   = ctrl.stall_decode;
    assign bubble_execute = ctrl.bubble_execute;
endmodule

// File: rtl/fwd_hazard_chk.sv
module fwd_hazard_chk
    import fwd_pkg::*;
(
    input logic [REG_ID_W-1:0] dec_src_a,
    input logic [REG_ID_W-1:0] dec_src_b,
    input logic [DATA_W-1:0]   rf_data_a,
    input logic [REG_ID_W-1:0] ex_dst,
    input logic [REG_ID_W-1:0] mem_dst,
    input logic [DATA_W-1:0]   mem_load_val,
    input logic [REG_ID_W-1:0] wb_dst,
    input logic [DATA_W-1:0]   wb_val,
    input logic [DATA_W-1:0]   opnd_a,
    input logic                stall_fetch,
    input logic                stall_decode,
    input logic                bubble_execute
);
    always_comb begin
        if (dec_src_a == REG_NONE)
            p_none_zero_r1: assert (opnd_a == '0);
        if (dec_src_a != REG_NONE && dec_src_a == mem_dst)
            p_mem_first_r2: assert (opnd_a == mem_load_val);
        if (dec_src_a != REG_NONE && dec_src_a != mem_dst && dec_src_a == wb_dst)
            p_wb_second_r3: assert (opnd_a == wb_val);
        if (dec_src_a != REG_NONE && dec_src_a != mem_dst && dec_src_a != wb_dst)
            p_rf_default_r4: assert (opnd_a == rf_data_a);
        if (ex_dst != REG_NONE && (ex_dst == dec_src_a || ex_dst == dec_src_b))
            p_interlock_r6: assert (stall_fetch && stall_decode && bubble_execute);
        if (ex_dst == REG_NONE)
            p_no_stall_r7: assert (!stall_fetch && !stall_decode && !bubble_execute);
    end
endmodule

bind fwd_hazard_ctrl fwd_hazard_chk u_chk (
    .dec_src_a      (dec_src_a),
    .dec_src_b      (dec_src_b),
    .rf_data_a      (rf_data_a),
    .ex_dst         (ex_dst),
    .mem_dst        (mem_dst),
    .mem_load_val   (mem_load_val),
    .wb_dst         (wb_dst),
    .wb_val         (wb_val),
    .opnd_a         (opnd_a),
    .stall_fetch    (stall_fetch),
    .stall_decode   (stall_decode),
    .bubble_execute (bubble_execute)
);

// File: tb/fwd_hazard_ctrl_bench.sv
module fwd_hazard_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [3:0] NONE = 4'hF;

    logic clk = 0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [3:0]  dec_src_a, dec_src_b, ex_dst, mem_dst, wb_dst;
    logic [63:0] rf_data_a, rf_data_b, mem_load_val, wb_val, opnd_a, opnd_b;
    logic        stall_fetch, stall_decode, bubble_execute;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    fwd_hazard_ctrl u_fwd_hazard_ctrl (.*);

    function automatic logic [63:0] rfa(logic [3:0] s); return 64'hA1A1_0000_0000_0000 | 64'(s); endfunction
    function automatic logic [63:0] rfb(logic [3:0] s); return 64'hB2B2_0000_0000_0000 | 64'(s); endfunction
    function automatic logic [63:0] mv(logic [3:0] d);  return 64'hC3C3_0000_0000_0000 | (64'(d) << 8); endfunction
    function automatic logic [63:0] wv(logic [3:0] d);  return 64'hD4D4_0000_0000_0000 | (64'(d) << 16); endfunction

    function automatic logic [63:0] expect_opnd(logic [3:0] s, logic [63:0] r, logic [3:0] m, logic [3:0] w);
        if (s == NONE) return 64'h0;
        if (s == m)    return mv(m);
        if (s == w)    return wv(w);
        return r;
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h (a=%h b=%h ex=%h m=%h w=%h)",
                     req, act, exp, dec_src_a, dec_src_b, ex_dst, mem_dst, wb_dst);
        end
    endtask

    task automatic apply(logic [3:0] a, logic [3:0] b, logic [3:0] e, logic [3:0] m, logic [3:0] w);
        @(posedge clk);
        dec_src_a = a; dec_src_b = b; ex_dst = e; mem_dst = m; wb_dst = w;
        rf_data_a = rfa(a); rf_data_b = rfb(b);
        mem_load_val = mv(m); wb_val = wv(w);
        @(negedge clk);
    endtask

    initial begin
        // idle state: everything 4'hF, R1 and R7
        apply(NONE, NONE, NONE, NONE, NONE);
        chk("R1 idle a", opnd_a, 64'h0);
        chk("R1 idle b", opnd_b, 64'h0);
        chk("R7 idle ctrl", {61'h0, stall_fetch, stall_decode, bubble_execute}, 64'h0);

        // sweep operand A against all memory/writeback destinations (R1-R5, R8 cases)
        for (int a = 0; a < 16; a++)
            for (int m = 0; m < 16; m++)
                for (int w = 0; w < 16; w++) begin
                    logic [3:0] b4;
                    b4 = 4'((a + 5) % 16);
                    apply(4'(a), b4, NONE, 4'(m), 4'(w));
                    chk("R2/R3/R4/R8 opnd_a", opnd_a, expect_opnd(4'(a), rfa(4'(a)), 4'(m), 4'(w)));
                    chk("R5 opnd_b", opnd_b, expect_opnd(b4, rfb(b4), 4'(m), 4'(w)));
                    if (a == 15) chk("R1 none a", opnd_a, 64'h0);
                    chk("R7 no ex load", {61'h0, stall_fetch, stall_decode, bubble_execute}, 64'h0);
                end

        // sweep interlock: sources against execute destination (R6, R7)
        for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++)
                for (int e = 0; e < 16; e++) begin
                    logic hz;
                    hz = (e != 15) && (e == a || e == b);
                    apply(4'(a), 4'(b), 4'(e), NONE, NONE);
                    chk(hz ? "R6 interlock" : "R7 no interlock",
                        {61'h0, stall_fetch, stall_decode, bubble_execute},
                        hz ? 64'h7 : 64'h0);
                    chk("R4 rf a", opnd_a, (a == 15) ? 64'h0 : rfa(4'(a)));
                    chk("R5 rf b", opnd_b, (b == 15) ? 64'h0 : rfb(4'(b)));
                end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule